// File: doc/BRIEF.md
# Ethernet PHY Status LED Driver

This block drives six active-high status lamps for a copper Ethernet PHY: full duplex, link at 10, link at 100, link at 1000, receive activity and transmit activity. Its inputs are the link state, a two-bit speed code, the duplex state and single-cycle receive and transmit activity strobes. It also takes a millisecond tick derived from the system clock.

Two 16-bit registers are written through a small write port. The control register holds a global lamp disable, an activity pulse-stretch code, a blink-rate code and three display-mode bits. The manual register holds one two-bit mode per lamp, which can leave the lamp following status or make it blink, stay off or stay on. Written values are staged and become active only on the next tick.

Activity strobes are stretched by a tick-driven timer so that short packets stay visible. Each new strobe restarts the timer. A single free-running square wave serves every lamp that is set to blink. All lamp outputs are registered.

Top module: `phy_led_driver`

## Requirements
- R1: During and after reset, with all status inputs low, every lamp output is 0. Reset leaves both registers active as all zeros.
- R2: In normal mode with `link_up` high, `speed` 0, 1 or 2 lights only `led_10`, `led_100` or `led_1000` respectively. Speed 3 or link down lights none of them.
- R3: With control bit 2 = 0, `led_dup` is on while link is up and `full_duplex` is high. With bit 2 = 1 it is additionally dark while either stretched activity is active.
- R4: With control bit 1 (rx) or bit 0 (tx) = 0, that activity lamp is on exactly while its stretched activity is active.
- R5: With control bit 1 or bit 0 = 1, that activity lamp is on while link is up, dark while its stretched activity is active, and dark when link is down.
- R6: Stretch code = control bits 14:12. Code 0 gives one cycle of activity per strobe. Code c of 1 to 7 gives 21·2^(c-1) ticks (21 up to 1344), counted from the strobe. A new strobe restarts the window.
- R7: Blink code = control bits 10:8. The blink wave spends 21·2^min(code,4) ticks in each phase, so codes 5 to 7 act as 4. The wave starts in the dark phase after reset and is common to every blinking lamp.
- R8: Manual register fields: tx bits 1:0, rx 3:2, link-1000 5:4, link-100 7:6, link-10 9:8, duplex 11:10. Each field is encoded 0 = follow status, 1 = blink, 2 = off, 3 = on.
- R9: Control bit 15 = 1 holds all six lamps dark, regardless of the manual fields.
- R10: A write with `reg_sel` 0 targets the control register and `reg_sel` 1 the manual register. The write has no effect on any lamp until a clock edge with `tick_ms` high has passed.
- R11: Each lamp output changes one clock after the inputs or active register values that determine it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_ms | input | 1 | One-cycle pulse per millisecond |
| link_up | input | 1 | Link established |
| speed | input | 2 | 0 = 10, 1 = 100, 2 = 1000, 3 = none |
| full_duplex | input | 1 | Duplex resolved as full |
| rx_act | input | 1 | Receive activity strobe |
| tx_act | input | 1 | Transmit activity strobe |
| reg_we | input | 1 | Register write enable |
| reg_sel | input | 1 | 0 = control, 1 = manual register |
| reg_wdata | input | DATA_W | Write data |
| led_dup | output | 1 | Duplex lamp |
| led_10 | output | 1 | Link-10 lamp |
| led_100 | output | 1 | Link-100 lamp |
| led_1000 | output | 1 | Link-1000 lamp |
| led_rx | output | 1 | Receive activity lamp |
| led_tx | output | 1 | Transmit activity lamp |

## Verification
Fourteen static status and register combinations are walked from a table. They separate speed decoding, duplex gating, the two activity display modes, each manual mode and the global disable. Single strobes at stretch codes 0, 1, 2, 3 and 7 measure the exact lit window, which shows whether the length doubles per code. A second strobe inside the window shows the timer restart. Blink runs at codes 0, 2 and a reserved code check the clamp and that all lamps blink in step. Writes made while the tick is held low show the staging to the tick boundary and the dark starting phase of the blink wave.

// File: rtl/phy_led_pkg.sv
package phy_led_pkg;
   typedef enum logic [1:0] {
      MODE_FOLLOW = 2'd0,
      MODE_BLINK  = 2'd1,
      MODE_DARK   = 2'd2,
      MODE_LIT    = 2'd3
   } lamp_mode_e;

   localparam int NUM_LAMPS = 6;
   localparam int IDX_TX    = 0;
   localparam int IDX_RX    = 1;
   localparam int IDX_G1000 = 2;
   localparam int IDX_M100  = 3;
   localparam int IDX_M10   = 4;
   localparam int IDX_DUP   = 5;

   function automatic logic lamp_resolve(lamp_mode_e m, logic status, logic wave);
      logic r;
      unique case (m)
         MODE_FOLLOW: r = status;
         MODE_BLINK:  r = wave;
         MODE_DARK:   r = 1'b0;
         default:     r = 1'b1;
      endcase
      return r;
   endfunction
endpackage

// File: rtl/phy_led_regs.sv
module phy_led_regs #(
   parameter int DATA_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick,
   input  logic              we,
   input  logic              sel,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] ctrl_act,
   output logic [DATA_W-1:0] man_act
);
   logic [DATA_W-1:0] ctrl_stg, man_stg;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ctrl_stg <= '0;
         man_stg  <= '0;
         ctrl_act <= '0;
         man_act  <= '0;
      end else begin
         if (we && !sel) ctrl_stg <= wdata;
         if (we && sel)  man_stg  <= wdata;
         if (tick) begin
            ctrl_act <= ctrl_stg;
            man_act  <= man_stg;
         end
      end
   end

   // R10
   hold_between_ticks_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !tick |=> ($stable(ctrl_act) && $stable(man_act)));
endmodule

// File: rtl/phy_led_stretch.sv
module phy_led_stretch #(
   parameter int BASE_TICKS = 21,
   parameter int CODE_W     = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick,
   input  logic              strobe,
   input  logic [CODE_W-1:0] code,
   output logic              active
);
   localparam int MAX_LEN = BASE_TICKS << ((1 << CODE_W) - 2);
   localparam int CW      = $clog2(MAX_LEN + 1);

   if (BASE_TICKS < 1) begin : g_bad_base
      $error("phy_led_stretch: BASE_TICKS must be at least 1");
   end

   logic [CW-1:0] remain, len_c;
   logic          first;

   always_comb begin
      if (code == '0) len_c = '0;
      else            len_c = CW'(BASE_TICKS) << (code - 1'b1);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         remain <= '0;
         first  <= 1'b0;
      end else begin
         first <= strobe;
         if (strobe)                    remain <= len_c;
         else if (tick && remain != '0) remain <= remain - 1'b1;
      end
   end

   assign active = first | (remain != '0);

   // R6
   strobe_lights_chk: assert property (@(posedge clk) disable iff (!rst_n)
      strobe |=> active);
   // R6
   window_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      remain <= CW'(MAX_LEN));
   // R6
   frozen_without_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!strobe && !tick) |=> $stable(remain));
endmodule

// File: rtl/phy_led_blink.sv
module phy_led_blink #(
   parameter int HALF_BASE = 21,
   parameter int CODE_W    = 3,
   parameter int MAX_CODE  = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick,
   input  logic [CODE_W-1:0] code,
   output logic              wave
);
   localparam int MAX_HALF = HALF_BASE << MAX_CODE;
   localparam int CW       = $clog2(MAX_HALF + 1);

   if (MAX_CODE >= (1 << CODE_W)) begin : g_bad_clamp
      $error("phy_led_blink: MAX_CODE does not fit in CODE_W");
   end

   logic [CODE_W-1:0] eff;
   logic [CW-1:0]     half, cnt;

   always_comb begin
      eff  = (code > CODE_W'(MAX_CODE)) ? CODE_W'(MAX_CODE) : code;
      half = CW'(HALF_BASE) << eff;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt  <= '0;
         wave <= 1'b0;
      end else if (tick) begin
         if (cnt >= half - 1'b1) begin
            cnt  <= '0;
            wave <= ~wave;
         end else begin
            cnt <= cnt + 1'b1;
         end
      end
   end

   // R7
   wave_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !tick |=> $stable(wave));
   // R7
   phase_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cnt < CW'(MAX_HALF));
endmodule

// File: rtl/phy_led_driver.sv
module phy_led_driver
   import phy_led_pkg::*;
#(
   parameter int DATA_W       = 16,
   parameter int STRETCH_BASE = 21,
   parameter int BLINK_BASE   = 21
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick_ms,
   input  logic              link_up,
   input  logic [1:0]        speed,
   input  logic              full_duplex,
   input  logic              rx_act,
   input  logic              tx_act,
   input  logic              reg_we,
   input  logic              reg_sel,
   input  logic [DATA_W-1:0] reg_wdata,
   output logic              led_dup,
   output logic              led_10,
   output logic              led_100,
   output logic              led_1000,
   output logic              led_rx,
   output logic              led_tx
);
   localparam int CODE_W    = 3;
   localparam int BIT_OFF   = 15;
   localparam int STR_LSB   = 12;
   localparam int BLK_LSB   = 8;
   localparam int BIT_DUPM  = 2;
   localparam int BIT_RXM   = 1;
   localparam int BIT_TXM   = 0;
   localparam int FIELD_W   = 2;

   if (DATA_W < 16) begin : g_bad_width
      $error("phy_led_driver: DATA_W must be at least 16");
   end

   logic [DATA_W-1:0]    ctrl_a, man_a;
   logic [1:0]           act_in, act_s, mode_bit;
   logic                 wave, lamps_off;
   logic [NUM_LAMPS-1:0] status, lamp_q;

   phy_led_regs #(.DATA_W(DATA_W)) u_regs (
      .clk(clk), .rst_n(rst_n), .tick(tick_ms), .we(reg_we), .sel(reg_sel),
      .wdata(reg_wdata), .ctrl_act(ctrl_a), .man_act(man_a)
   );

   // index 0 = transmit, index 1 = receive
   assign act_in   = {rx_act, tx_act};
   assign mode_bit = {ctrl_a[BIT_RXM], ctrl_a[BIT_TXM]};

   for (genvar a = 0; a < 2; a++) begin : g_act
      phy_led_stretch #(.BASE_TICKS(STRETCH_BASE), .CODE_W(CODE_W)) u_str (
         .clk(clk), .rst_n(rst_n), .tick(tick_ms), .strobe(act_in[a]),
         .code(ctrl_a[STR_LSB +: CODE_W]), .active(act_s[a])
      );
      assign status[IDX_TX + a] = mode_bit[a] ? (link_up & ~act_s[a]) : act_s[a];
   end

   phy_led_blink #(.HALF_BASE(BLINK_BASE), .CODE_W(CODE_W), .MAX_CODE(4)) u_blink (
      .clk(clk), .rst_n(rst_n), .tick(tick_ms),
      .code(ctrl_a[BLK_LSB +: CODE_W]), .wave(wave)
   );

   assign status[IDX_G1000] = link_up && (speed == 2'd2);
   assign status[IDX_M100]  = link_up && (speed == 2'd1);
   assign status[IDX_M10]   = link_up && (speed == 2'd0);
   assign status[IDX_DUP]   = link_up && full_duplex &&
                              !(ctrl_a[BIT_DUPM] && (act_s[0] || act_s[1]));
   assign lamps_off         = ctrl_a[BIT_OFF];

   for (genvar i = 0; i < NUM_LAMPS; i++) begin : g_lamp
      lamp_mode_e mode;
      assign mode = lamp_mode_e'(man_a[FIELD_W*i +: FIELD_W]);

      always_ff @(posedge clk) begin
         if (!rst_n) lamp_q[i] <= 1'b0;
         else        lamp_q[i] <= !lamps_off && lamp_resolve(mode, status[i], wave);
      end

      // R8
      forced_lit_chk: assert property (@(posedge clk) disable iff (!rst_n)
         $past(mode == MODE_LIT && !lamps_off) |-> lamp_q[i]);
      // R8
      forced_dark_chk: assert property (@(posedge clk) disable iff (!rst_n)
         $past(mode == MODE_DARK) |-> !lamp_q[i]);
   end

   assign led_tx   = lamp_q[IDX_TX];
   assign led_rx   = lamp_q[IDX_RX];
   assign led_1000 = lamp_q[IDX_G1000];
   assign led_100  = lamp_q[IDX_M100];
   assign led_10   = lamp_q[IDX_M10];
   assign led_dup  = lamp_q[IDX_DUP];

   logic unused_bits;
   assign unused_bits = ^{ctrl_a[DATA_W-1:BIT_OFF+1], ctrl_a[11], ctrl_a[7:3],
                          man_a[DATA_W-1:FIELD_W*NUM_LAMPS]};

   // R9
   disable_dark_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $past(lamps_off) |-> (lamp_q == '0));
   // R2
   one_speed_lamp_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $past(man_a[9:4] == 6'd0) |-> $onehot0({led_10, led_100, led_1000}));
endmodule

// File: tb/tb_phy_led_driver.sv
module tb_phy_led_driver;
   localparam int CLK_PERIOD = 10;
   localparam int NV = 14;
   // {ctrl, manual, link, speed, duplex, expected {dup,10,100,1000,rx,tx}}
   localparam logic [41:0] VEC [NV] = '{
      {16'h0000, 16'h0000, 1'b1, 2'd0, 1'b1, 6'b110000},
      {16'h0000, 16'h0000, 1'b1, 2'd1, 1'b0, 6'b001000},
      {16'h0000, 16'h0000, 1'b1, 2'd2, 1'b1, 6'b100100},
      {16'h0000, 16'h0000, 1'b1, 2'd3, 1'b1, 6'b100000},
      {16'h0000, 16'h0000, 1'b0, 2'd2, 1'b1, 6'b000000},
      {16'h0003, 16'h0000, 1'b1, 2'd2, 1'b0, 6'b000111},
      {16'h0003, 16'h0000, 1'b0, 2'd2, 1'b0, 6'b000000},
      {16'h0003, 16'h0AAA, 1'b1, 2'd0, 1'b1, 6'b000000},
      {16'h0000, 16'h0FFF, 1'b0, 2'd0, 1'b0, 6'b111111},
      {16'h0000, 16'h000C, 1'b0, 2'd0, 1'b0, 6'b000010},
      {16'h0000, 16'h0C00, 1'b0, 2'd0, 1'b0, 6'b100000},
      {16'h8000, 16'h0FFF, 1'b1, 2'd0, 1'b1, 6'b000000},
      {16'h0000, 16'h0300, 1'b1, 2'd2, 1'b0, 6'b010100},
      {16'h0004, 16'h0000, 1'b1, 2'd1, 1'b1, 6'b101000}
   };
   localparam string VTAG [NV] = '{"R2", "R2", "R2", "R2", "R2", "R5", "R5",
                                   "R8", "R8", "R8", "R8", "R9", "R8", "R3"};

   logic clk = 1'b0, rst_n = 1'b0, tick_ms = 1'b0;
   logic link_up = 1'b0, full_duplex = 1'b0, rx_act = 1'b0, tx_act = 1'b0;
   logic [1:0] speed = 2'd3;
   logic reg_we = 1'b0, reg_sel = 1'b0;
   logic [15:0] reg_wdata = '0;
   logic led_dup, led_10, led_100, led_1000, led_rx, led_tx;
   logic [5:0] leds;
   int n_chk = 0, n_fail = 0;

   assign leds = {led_dup, led_10, led_100, led_1000, led_rx, led_tx};

   always #(CLK_PERIOD/2) clk = ~clk;

   phy_led_driver dut (
      .clk(clk), .rst_n(rst_n), .tick_ms(tick_ms), .link_up(link_up),
      .speed(speed), .full_duplex(full_duplex), .rx_act(rx_act), .tx_act(tx_act),
      .reg_we(reg_we), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
      .led_dup(led_dup), .led_10(led_10), .led_100(led_100),
      .led_1000(led_1000), .led_rx(led_rx), .led_tx(led_tx)
   );

   task automatic chk(input string tag, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual %0d (0x%0h) expected %0d (0x%0h)", tag, act, act, exp, exp);
      end
   endtask

   task automatic cyc(input int n);
      for (int k = 0; k < n; k++) @(negedge clk);
   endtask

   task automatic wr(input logic sel, input logic [15:0] d);
      reg_we = 1'b1; reg_sel = sel; reg_wdata = d;
      @(negedge clk);
      reg_we = 1'b0;
   endtask

   task automatic pulse(input bit rx);
      if (rx) rx_act = 1'b1; else tx_act = 1'b1;
      @(negedge clk);
      rx_act = 1'b0; tx_act = 1'b0;
   endtask

   // count cycles in which lamp idx equals val over a window
   task automatic count_val(input int idx, input logic val, input int win, output int n);
      n = 0;
      for (int k = 0; k < win; k++) begin
         @(negedge clk);
         if (leds[idx] == val) n++;
      end
   endtask

   task automatic blink_run(output int n, output int skew);
      int g;
      n = 0; skew = 0; g = 0;
      while (leds[0] !== 1'b0 && g < 2000) begin @(negedge clk); g++; end
      while (leds[0] !== 1'b1 && g < 4000) begin @(negedge clk); g++; end
      while (leds[0] === 1'b1 && g < 6000) begin
         if (leds != 6'h3F) skew++;
         n++; @(negedge clk); g++;
      end
   endtask

   task automatic stretch_case(input string tag, input logic [15:0] ctrl,
                               input bit rx, input int exp);
      int n;
      wr(1'b0, ctrl); cyc(4);
      pulse(rx);
      count_val(rx ? 1 : 0, 1'b1, exp + 40, n);
      chk(tag, n, exp);
   endtask

   initial begin
      int n, sk;
      cyc(3);
      chk("R1 reset lamps", int'(leds), 0);
      rst_n = 1'b1;
      cyc(3);
      chk("R1 lamps after reset", int'(leds), 0);

      // R10: staged writes wait for a tick
      wr(1'b1, 16'h0FFF); cyc(5);
      chk("R10 no effect before tick", int'(leds), 0);
      tick_ms = 1'b1; @(negedge clk); tick_ms = 1'b0; cyc(2);
      chk("R10 effect after tick", int'(leds), 'h3F);
      wr(1'b1, 16'h0555); cyc(5);
      chk("R10 old value held", int'(leds), 'h3F);
      tick_ms = 1'b1; @(negedge clk); tick_ms = 1'b0; cyc(2);
      chk("R7 blink starts dark", int'(leds), 0);

      tick_ms = 1'b1;
      wr(1'b1, 16'h0000); cyc(3);

      // table walk: R2 R3 R5 R8 R9 R11
      for (int v = 0; v < NV; v++) begin
         wr(1'b0, VEC[v][41:26]);
         wr(1'b1, VEC[v][25:10]);
         link_up = VEC[v][9]; speed = VEC[v][8:7]; full_duplex = VEC[v][6];
         cyc(4);
         chk(VTAG[v], int'(leds), int'(VEC[v][5:0]));
      end

      // R11: one-clock latency from a status input
      wr(1'b0, 16'h0000); wr(1'b1, 16'h0000);
      link_up = 1'b1; speed = 2'd2; cyc(4);
      speed = 2'd1; #1;
      chk("R11 before edge", int'(led_1000), 1);
      @(negedge clk);
      chk("R11 after one edge", int'({led_100, led_1000}), 2);

      // stretch windows: R4 R6
      link_up = 1'b0; cyc(2);
      stretch_case("R6 code0 rx", 16'h0000, 1'b1, 1);
      stretch_case("R6 code1 rx", 16'h1000, 1'b1, 21);
      stretch_case("R4 code2 tx", 16'h2000, 1'b0, 42);
      stretch_case("R6 code3 rx", 16'h3000, 1'b1, 84);
      stretch_case("R6 code7 tx", 16'h7000, 1'b0, 1344);

      // R6 restart on a second strobe
      wr(1'b0, 16'h1000); cyc(4);
      pulse(1'b1); cyc(9); pulse(1'b1);
      count_val(1, 1'b1, 80, n);
      chk("R6 restart", n + 10, 31);

      // R5 link-combined receive lamp
      link_up = 1'b1;
      wr(1'b0, 16'h1002); cyc(4);
      chk("R5 lit on idle link", int'(led_rx), 1);
      pulse(1'b1);
      count_val(1, 1'b0, 70, n);
      chk("R5 dark window", n, 21);

      // R3 duplex lamp dims on activity in mode 1
      full_duplex = 1'b1;
      wr(1'b0, 16'h1004); cyc(4);
      pulse(1'b0);
      count_val(5, 1'b0, 70, n);
      chk("R3 duplex dark window", n, 21);

      // R7 blink periods and clamp
      link_up = 1'b0; full_duplex = 1'b0;
      wr(1'b1, 16'h0555);
      wr(1'b0, 16'h0000); cyc(4);
      blink_run(n, sk);
      chk("R7 blink code0", n, 21);
      chk("R7 lamps in step", sk, 0);
      wr(1'b0, 16'h0200); cyc(4);
      blink_run(n, sk);
      chk("R7 blink code2", n, 84);
      wr(1'b0, 16'h0600); cyc(4);
      blink_run(n, sk);
      chk("R7 reserved code clamps", n, 336);

      // R9 disable dominates blink
      wr(1'b0, 16'h8000); cyc(4);
      count_val(0, 1'b1, 800, n);
      chk("R9 disabled no blink", n, 0);

      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      #(CLK_PERIOD * 200000);
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule